// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It fetches from an instruction memory port, decodes, reads two source registers, runs the ALU and writes back, all inside one cycle. The program counter advances on every rising clock edge. The core accepts a small load-store instruction set: word load, word store, add, subtract, and, or, signed set-on-less-than, branch-if-equal and an unconditional jump.

Decoding happens in two levels. The opcode decoder picks a 2-bit ALU class. A second decoder turns that class, plus the function field for register-type instructions, into a 3-bit ALU operation. Every register address, immediate and target comes from a fixed bit field of the instruction word.

The instruction and data memories sit outside the core. Both are read combinationally within the cycle. The data memory takes a write on the clock edge at the end of a cycle whose write enable is high.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, sets the program counter to 0. The instruction address reads 0 in the cycle after that edge.
- R2: Opcodes 000000, 100011 and 101011 (bits 31-26) advance the program counter to PC+4 on the next edge.
- R3: Register-type instructions (opcode 000000) select the operation from funct (bits 5-0): 100000 add, 100010 subtract, 100100 and, 100101 or. The operands are the registers named in bits 25-21 and 20-16. The result is written to the register named in bits 15-11.
- R4: A word load (opcode 100011) raises the data read enable and drives the data address with base register (bits 25-21) plus the sign-extended offset (bits 15-0). It writes the read data into the register named in bits 20-16. The read enable is low for every other opcode.
- R5: A word store (opcode 101011) raises the data write enable, forms its address the same way as a load, and drives the write data with the register named in bits 20-16. The write enable is low for every other opcode.
- R6: Branch-if-equal (opcode 000100) loads PC+4 plus the sign-extended offset shifted left by two when the two source registers are equal. Otherwise it loads PC+4. It writes no register and no memory.
- R7: Jump (opcode 000010) loads the upper 4 bits of PC+4 joined with bits 25-0 shifted left by two.
- R8: Register 0 always reads as zero, and writes to it from loads or register-type instructions are discarded.
- R9: Any other opcode (for example 111111) writes no register and no memory, raises neither memory enable, and advances the PC by 4.
- R10: Set-on-less-than (funct 101010) writes 1 when the first source is smaller as a signed two's-complement number and 0 otherwise. Add and subtract wrap modulo 2^32 without trapping. The ALU overflow flag is raised only for add or subtract operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Instruction fetch address (program counter) |
| imem_data | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Data memory store data |
| dmem_rdata | input | 32 | Data memory load data at dmem_addr |
| dmem_rd_en | output | 1 | Data read enable, high only for loads |
| dmem_wr_en | output | 1 | Data write enable, high only for stores |

## Verification
Register contents are never visible at the ports, so a wrong ALU result, a misrouted write address or a lost write to register 0 shows only when a later store drives that register onto the write data. The stimulus therefore mixes register-type operations, loads and writes aimed at register 0 with frequent stores of the same small register set. A lock-step instruction model tags each stored value with the instruction that produced it. A directed prologue also loads the signed extremes, so that set-on-less-than and wrapping add or subtract meet operands of opposite sign.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam logic [5:0] OPC_REG   = 6'b000000;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_JUMP  = 6'b000010;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   typedef enum logic [1:0] {
      CLS_ADD   = 2'b00,
      CLS_SUB   = 2'b01,
      CLS_FUNCT = 2'b10
   } alu_cls_e;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   typedef struct packed {
      logic     wr_sel_rd;
      logic     b_sel_imm;
      logic     wb_sel_mem;
      logic     reg_we;
      logic     mem_rd;
      logic     mem_wr;
      logic     is_branch;
      logic     is_jump;
      alu_cls_e cls;
   } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctl,
   output alu_op_e    alu_op
);

   always_comb begin
      ctl     = '0;
      ctl.cls = CLS_ADD;
      case (opcode)
         OPC_REG: begin
            ctl.wr_sel_rd = 1'b1;
            ctl.reg_we    = 1'b1;
            ctl.cls       = CLS_FUNCT;
         end
         OPC_LOAD: begin
            ctl.b_sel_imm  = 1'b1;
            ctl.wb_sel_mem = 1'b1;
            ctl.reg_we     = 1'b1;
            ctl.mem_rd     = 1'b1;
         end
         OPC_STORE: begin
            ctl.b_sel_imm = 1'b1;
            ctl.mem_wr    = 1'b1;
         end
         OPC_BEQ: begin
            ctl.is_branch = 1'b1;
            ctl.cls       = CLS_SUB;
         end
         OPC_JUMP: ctl.is_jump = 1'b1;
         default: ;
      endcase
   end

   always_comb begin
      case (ctl.cls)
         CLS_SUB:   alu_op = ALU_SUB;
         CLS_FUNCT: begin
            case (funct)
               FN_SUB:  alu_op = ALU_SUB;
               FN_AND:  alu_op = ALU_AND;
               FN_OR:   alu_op = ALU_OR;
               FN_SLT:  alu_op = ALU_SLT;
               default: alu_op = ALU_ADD;
            endcase
         end
         default:   alu_op = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero,
   output logic         ovf
);

   localparam int MSB = W - 1;

   logic [W-1:0] sum, diff;
   logic         lt;

   assign sum  = a + b;
   assign diff = a - b;
   assign lt   = $signed(a) < $signed(b);

   always_comb begin
      case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SUB: y = diff;
         ALU_SLT: y = {{MSB{1'b0}}, lt};
         default: y = sum;
      endcase
   end

   assign zero = (y == '0);

   always_comb begin
      case (op)
         ALU_ADD: ovf = (a[MSB] == b[MSB]) && (sum[MSB]  != a[MSB]);
         ALU_SUB: ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
         default: ovf = 1'b0;
      endcase
   end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int W    = 32,
   parameter int NREG = 32
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] waddr,
   input  logic [W-1:0]            wdata,
   input  logic [$clog2(NREG)-1:0] raddr_a,
   input  logic [$clog2(NREG)-1:0] raddr_b,
   output logic [W-1:0]            rdata_a,
   output logic [W-1:0]            rdata_b
);

   logic [W-1:0] rd_vec [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      if (i == 0) begin : g_zero
         assign rd_vec[i] = '0;
      end else begin : g_store
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (we && (waddr == i)) q <= wdata;
         end
         assign rd_vec[i] = q;
      end
   end

   assign rdata_a = rd_vec[raddr_a];
   assign rdata_b = rd_vec[raddr_b];

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int NREG = 32
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] imem_addr,
   input  logic [XLEN-1:0] imem_data,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic            dmem_rd_en,
   output logic            dmem_wr_en
);

   localparam int RAW    = $clog2(NREG);
   localparam int IMMW   = 16;
   localparam int JTW    = 26;
   localparam int PC_HI  = XLEN - JTW - 2;
   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_core: instruction format fixes XLEN at 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("sc_core: 5-bit register fields need NREG of 32");
   end

   logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_tgt, jmp_tgt, imm_ext;
   logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, wb_data;
   logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, wr_idx;
   logic            alu_zero, alu_ovf;
   ctrl_t           ctl;
   alu_op_e         alu_op;

   assign rs_idx  = imem_data[25:21];
   assign rt_idx  = imem_data[20:16];
   assign rd_idx  = imem_data[15:11];
   assign imm_ext = {{(XLEN-IMMW){imem_data[IMMW-1]}}, imem_data[IMMW-1:0]};

   sc_ctrl u_ctrl (
      .opcode (imem_data[31:26]),
      .funct  (imem_data[5:0]),
      .ctl    (ctl),
      .alu_op (alu_op)
   );

   assign wr_idx  = ctl.wr_sel_rd  ? rd_idx : rt_idx;
   assign wb_data = ctl.wb_sel_mem ? dmem_rdata : alu_y;

   sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
      .clk     (clk),
      .we      (ctl.reg_we),
      .waddr   (wr_idx),
      .wdata   (wb_data),
      .raddr_a (rs_idx),
      .raddr_b (rt_idx),
      .rdata_a (rs_val),
      .rdata_b (rt_val)
   );

   assign alu_b = ctl.b_sel_imm ? imm_ext : rt_val;

   sc_alu #(.W(XLEN)) u_alu (
      .a    (rs_val),
      .b    (alu_b),
      .op   (alu_op),
      .y    (alu_y),
      .zero (alu_zero),
      .ovf  (alu_ovf)
   );

   assign pc_plus4 = pc_q + STEP;
   assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
   assign jmp_tgt  = {pc_plus4[XLEN-1 -: PC_HI], imem_data[JTW-1:0], 2'b00};

   always_comb begin
      if (ctl.is_jump)                    pc_next = jmp_tgt;
      else if (ctl.is_branch && alu_zero) pc_next = br_tgt;
      else                                pc_next = pc_plus4;
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   assign imem_addr  = pc_q;
   assign dmem_addr  = alu_y;
   assign dmem_wdata = rt_val;
   assign dmem_rd_en = ctl.mem_rd;
   assign dmem_wr_en = ctl.mem_wr;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
   import sc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic [XLEN-1:0] imem_addr,
   input logic [XLEN-1:0] imem_data,
   input logic            dmem_rd_en,
   input logic            dmem_wr_en,
   input logic            alu_ovf,
   input logic [2:0]      alu_op
);

   logic [5:0]      opc;
   logic [XLEN-1:0] seq_pc, jtgt, btgt;
   logic            is_seq, is_known;

   assign opc      = imem_data[31:26];
   assign seq_pc   = imem_addr + XLEN'(4);
   assign jtgt     = {seq_pc[XLEN-1 -: 4], imem_data[25:0], 2'b00};
   assign btgt     = seq_pc + {{(XLEN-18){imem_data[15]}}, imem_data[15:0], 2'b00};
   assign is_known = (opc == OPC_REG) || (opc == OPC_LOAD) || (opc == OPC_STORE) ||
                     (opc == OPC_BEQ) || (opc == OPC_JUMP);
   assign is_seq   = (opc != OPC_BEQ) && (opc != OPC_JUMP);

   AST_RESET_PC: assert property (@(posedge clk) rst |=> (imem_addr == '0)); // R1
   AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
      is_seq |=> (imem_addr == $past(seq_pc))); // R2
   AST_LOAD_RDEN: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_LOAD) |-> (dmem_rd_en && !dmem_wr_en)); // R4
   AST_NOLOAD_RDEN: assert property (@(posedge clk) disable iff (rst)
      (opc != OPC_LOAD) |-> !dmem_rd_en); // R4
   AST_STORE_WREN: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_STORE) |-> (dmem_wr_en && !dmem_rd_en)); // R5
   AST_NOSTORE_WREN: assert property (@(posedge clk) disable iff (rst)
      (opc != OPC_STORE) |-> !dmem_wr_en); // R5
   AST_BRANCH_PC: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_BEQ) |=> ((imem_addr == $past(seq_pc)) || (imem_addr == $past(btgt)))); // R6
   AST_JUMP_PC: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_JUMP) |=> (imem_addr == $past(jtgt))); // R7
   AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
      !is_known |-> (!dmem_wr_en && !dmem_rd_en)); // R9
   AST_OVF_ARITH: assert property (@(posedge clk) disable iff (rst)
      alu_ovf |-> ((alu_op == ALU_ADD) || (alu_op == ALU_SUB))); // R10

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .imem_addr  (imem_addr),
   .imem_data  (imem_data),
   .dmem_rd_en (dmem_rd_en),
   .dmem_wr_en (dmem_wr_en),
   .alu_ovf    (alu_ovf),
   .alu_op     (alu_op)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;

   localparam int WDOG = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_rd_en, dmem_wr_en;

   logic [31:0] im [64];
   logic [31:0] dm [64];
   logic [31:0] mm [64];
   logic [31:0] mr [32];
   string       mtag [32];
   logic [31:0] mpc;
   string       pc_tag;
   int          n_chk = 0, n_err = 0, cyc = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign imem_data  = im[imem_addr[7:2]];
   assign dmem_rdata = dm[dmem_addr[7:2]];

   sc_core u0 (
      .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
      .dmem_rd_en(dmem_rd_en), .dmem_wr_en(dmem_wr_en)
   );

   function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
      return {6'b000000, rs, rt, rd, 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction
   function automatic logic [31:0] enc_j(logic [25:0] t);
      return {6'b000010, t};
   endfunction
   function automatic logic [31:0] sext(logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Lock-step model: compare ports with the model, then advance the model one instruction.
   task automatic step();
      logic [31:0] ins, a, b, res, nxt, addr;
      logic [5:0]  op, fn;
      logic [4:0]  rs, rt, rd;
      string       t;
      ins = im[mpc[7:2]];
      chk(pc_tag, "pc", imem_addr, mpc);
      op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
      a = mr[rs]; b = mr[rt];
      nxt = mpc + 32'd4; pc_tag = "R2";
      addr = a + sext(ins[15:0]);
      case (op)
         6'b000000: begin
            t = "R3";
            case (fn)
               6'b100000: res = a + b;
               6'b100010: res = a - b;
               6'b100100: res = a & b;
               6'b100101: res = a | b;
               default: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; t = "R10"; end
            endcase
            chk("R3", "rd_en", {31'd0, dmem_rd_en}, 32'd0);
            chk("R3", "wr_en", {31'd0, dmem_wr_en}, 32'd0);
            if (rd != 0) begin mr[rd] = res; mtag[rd] = t; end
         end
         6'b100011: begin
            chk("R4", "rd_en", {31'd0, dmem_rd_en}, 32'd1);
            chk("R4", "wr_en", {31'd0, dmem_wr_en}, 32'd0);
            chk("R4", "load addr", dmem_addr, addr);
            if (rt != 0) begin mr[rt] = mm[addr[7:2]]; mtag[rt] = "R4"; end
         end
         6'b101011: begin
            chk("R5", "wr_en", {31'd0, dmem_wr_en}, 32'd1);
            chk("R5", "rd_en", {31'd0, dmem_rd_en}, 32'd0);
            chk("R5", "store addr", dmem_addr, addr);
            chk((rt == 0) ? "R8" : mtag[rt], "store data", dmem_wdata, b);
            mm[addr[7:2]] = b;
         end
         6'b000100: begin
            chk("R6", "wr_en", {31'd0, dmem_wr_en}, 32'd0);
            chk("R6", "rd_en", {31'd0, dmem_rd_en}, 32'd0);
            if (a == b) nxt = mpc + 32'd4 + {sext(ins[15:0]), 2'b00};
            pc_tag = "R6";
         end
         6'b000010: begin
            nxt = {mpc[31:28] + ((mpc[27:0] >= 28'hFFFFFFC) ? 4'd1 : 4'd0), ins[25:0], 2'b00};
            chk("R7", "wr_en", {31'd0, dmem_wr_en}, 32'd0);
            pc_tag = "R7";
         end
         default: begin
            chk("R9", "wr_en", {31'd0, dmem_wr_en}, 32'd0);
            chk("R9", "rd_en", {31'd0, dmem_rd_en}, 32'd0);
            pc_tag = "R9";
         end
      endcase
      if (dmem_wr_en) dm[dmem_addr[7:2]] = dmem_wdata;
      mpc = nxt;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "pc in reset", imem_addr, 32'd0);
      for (int i = 0; i < 32; i++) begin mr[i] = '0; mtag[i] = "R8"; end
      mpc = '0; pc_tag = "R1";
      rst = 1'b0;
   endtask

   function automatic logic [31:0] rand_ins();
      logic [4:0] r1, r2, r3;
      logic [5:0] fns [5];
      logic [5:0] bad [3];
      fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100; fns[3] = 6'b100101; fns[4] = 6'b101010;
      bad[0] = 6'b111111; bad[1] = 6'b001000; bad[2] = 6'b000011;
      r1 = 5'($urandom % 8); r2 = 5'($urandom % 8); r3 = 5'($urandom % 8);
      case ($urandom % 16)
         6, 7:   return enc_i(6'b100011, 5'd0, r1, 16'(4 * ($urandom % 64)));
         8, 9:   return enc_i(6'b101011, 5'd0, r1, 16'(4 * ($urandom % 64)));
         10, 11: return enc_i(6'b000100, 5'(r1 % 4), 5'(r2 % 4), 16'($urandom % 5));
         12:     return enc_j(26'($urandom % 64));
         13:     return {bad[$urandom % 3], r1, r2, 16'($urandom)};
         default: return enc_r(fns[$urandom % 5], r1, r2, r3);
      endcase
   endfunction

   initial begin : watchdog
      wait (cyc > WDOG);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      // Directed program
      for (int i = 0; i < 64; i++) begin
         im[i] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);
         dm[i] = 32'hDEAD_0000 + 32'(i);
      end
      dm[0] = 32'h7FFF_FFFF; dm[1] = 32'd1; dm[2] = 32'h8000_0000; dm[3] = 32'hFFFF_FFFF;
      im[0]  = enc_i(6'b100011, 0, 1, 16'd0);
      im[1]  = enc_i(6'b100011, 0, 2, 16'd4);
      im[2]  = enc_i(6'b100011, 0, 3, 16'd8);
      im[3]  = enc_i(6'b100011, 0, 4, 16'd12);
      im[4]  = enc_r(6'b100000, 5, 1, 2);
      im[5]  = enc_i(6'b101011, 0, 5, 16'd64);
      im[6]  = enc_r(6'b101010, 6, 3, 2);
      im[7]  = enc_i(6'b101011, 0, 6, 16'd68);
      im[8]  = enc_r(6'b101010, 7, 2, 4);
      im[9]  = enc_i(6'b101011, 0, 7, 16'd72);
      im[10] = enc_r(6'b100010, 5, 3, 2);
      im[11] = enc_i(6'b101011, 0, 5, 16'd76);
      im[12] = enc_r(6'b100100, 6, 1, 4);
      im[13] = enc_r(6'b100101, 7, 2, 3);
      im[14] = enc_i(6'b101011, 0, 7, 16'd100);
      im[15] = enc_r(6'b100000, 0, 1, 2);
      im[16] = enc_i(6'b101011, 0, 0, 16'd80);
      im[17] = enc_i(6'b100011, 0, 0, 16'd0);
      im[18] = enc_i(6'b101011, 0, 0, 16'd84);
      im[19] = enc_i(6'b000100, 1, 2, 16'd5);
      im[20] = enc_i(6'b000100, 3, 3, 16'd2);
      im[21] = enc_i(6'b101011, 0, 1, 16'd88);
      im[22] = enc_i(6'b101011, 0, 1, 16'd92);
      im[23] = {6'b111111, 5'd0, 5'd1, 16'd96};
      im[24] = enc_i(6'b101011, 0, 1, 16'd104);
      im[25] = enc_j(26'd30);
      im[26] = enc_i(6'b101011, 0, 1, 16'd108);
      for (int i = 0; i < 64; i++) mm[i] = dm[i];
      do_reset();
      repeat (60) begin step(); @(negedge clk); end
      chk("R10", "wrapped add", dm[16], 32'h8000_0000);
      chk("R10", "signed slt true", dm[17], 32'd1);
      chk("R10", "signed slt false", dm[18], 32'd0);
      chk("R3", "wrapped sub", dm[19], 32'h7FFF_FFFF);
      chk("R3", "or result", dm[25], 32'h8000_0001);
      chk("R8", "r0 after add", dm[20], 32'd0);
      chk("R8", "r0 after load", dm[21], 32'd0);
      chk("R6", "skipped store", dm[22], 32'hDEAD_0016);
      chk("R9", "unknown opcode", dm[24], 32'hDEAD_0018);
      chk("R7", "jump skipped store", dm[27], 32'hDEAD_001B);
      chk("R7", "jump target", imem_addr, 32'd120);
      // Random program
      rst = 1'b1;
      for (int i = 0; i < 64; i++) dm[i] = $urandom;
      dm[0] = 32'h8000_0000; dm[1] = 32'h7FFF_FFFF; dm[2] = 32'hFFFF_FFFF;
      for (int i = 0; i < 64; i++) mm[i] = dm[i];
      for (int k = 1; k < 8; k++) im[k-1] = enc_i(6'b100011, 0, 5'(k), 16'(4 * (k - 1)));
      for (int i = 7; i < 64; i++) im[i] = rand_ins();
      do_reset();
      repeat (4000) begin step(); @(negedge clk); end
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule